// File: doc/BRIEF.md
# Quadrant-Folding Thermometer Decoder for a Cosine-Weighted DAC

This block is the digital front end of a current-cell DAC whose cells are weighted so that their summed output follows a cosine. No sine lookup table is used. Each cycle the block takes a phase word. The two top bits of that word select one of four quarter-waves. In the second and fourth quarter the remaining bits are mirrored by bitwise complement, so every phase lands in the first quarter-wave.

The folded value is split into a row field (upper bits) and a column field (lower bits). Each field is thermometer decoded, and a small gate at every cell of the row-by-column matrix combines the two codes. As a result, exactly the cells whose index is below the folded value are on. The top phase bit selects the sign: it sets which leg of every cell's differential switch pair carries the current. Enables and switch pairs are registered together, so all cells change on the same clock edge.

Top module: `dac_quad_decoder`

## Requirements
- R1: While rst_ni is low, every cell enable is 0, every A line is 0 and every B line is 1.
- R2: Let L be the low PHASE_W-2 bits of the phase. If phase bit PHASE_W-2 is 0, the folded value F equals L. If that bit is 1, F equals 2^(PHASE_W-2)-1-L, the bitwise complement of L.
- R3: The number of asserted cell enables equals F.
- R4: Cell n, with n = row*2^COL_W + col, is enabled exactly when n < F. Equivalently, its row is below the upper ROW_W bits of F, or its row equals those bits and its column is below the lower COL_W bits of F.
- R5: For every cell, the A line equals the cell enable XOR phase bit PHASE_W-1, and the B line is always the complement of A.
- R6: All outputs reflect the phase sampled at the previous rising clock edge: one cycle of latency, with no output changing between edges.
- R7: When the phase steps by one (modulo 2^PHASE_W), at most one cell enable changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | PHASE_W | Phase word from the accumulator |
| cell_en_o | output | 2^(PHASE_W-2) | Registered cell enables, bit n = cell n |
| sw_a_o | output | 2^(PHASE_W-2) | Registered A leg of each cell's differential switch |
| sw_b_o | output | 2^(PHASE_W-2) | Registered B leg of each cell's differential switch |

## Verification
The assertions check four properties on every cycle against the previous cycle's phase: the enable population matches the folded phase, the enabled set is a contiguous run from cell 0, the sign rule holds, and A and B stay complementary. Only the bench's scenarios can show three other things. The first is the reset values. The second is the exact per-cell mask for every one of the 256 phases of the default configuration, including the mirrored quarters. The third is the single-cell change between consecutive phases, including the steps across quarter boundaries and the wrap from the last phase to zero.

// File: rtl/dac_quad_pkg.sv
package dac_quad_pkg;
  // Order matters: encoding is the two top phase bits.
  typedef enum logic [1:0] {
    Q_POS_RISE = 2'b00,
    Q_POS_FALL = 2'b01,
    Q_NEG_RISE = 2'b10,
    Q_NEG_FALL = 2'b11
  } quad_e;
endpackage

// File: rtl/dac_quad_fold.sv
module dac_quad_fold
  import dac_quad_pkg::*;
#(
  parameter int unsigned PHASE_W = 8,
  localparam int unsigned FOLD_W = PHASE_W - 2
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [FOLD_W-1:0]  folded_o,
  output logic               neg_o
);
  quad_e quad;
  logic  mirror;

  assign quad     = quad_e'(phase_i[PHASE_W-1 -: 2]);
  assign mirror   = (quad == Q_POS_FALL) || (quad == Q_NEG_FALL);
  assign neg_o    = (quad == Q_NEG_RISE) || (quad == Q_NEG_FALL);
  assign folded_o = phase_i[FOLD_W-1:0] ^ {FOLD_W{mirror}};
endmodule

// File: rtl/dac_therm.sv
module dac_therm #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned LINES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  below_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int unsigned IDX = i;
    assign below_o[i] = (IDX[CODE_W-1:0] < code_i);
  end
endmodule

// File: rtl/dac_cell_array.sv
module dac_cell_array #(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3,
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned COLS  = 1 << COL_W,
  localparam int unsigned CELLS = ROWS * COLS
) (
  input  logic [ROWS-1:0]  row_below_i,
  input  logic [COLS-1:0]  col_below_i,
  output logic [CELLS-1:0] en_o
);
  logic [ROWS-1:0] row_cur;

  // Current row = first row not below the code (thermometer edge).
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_first
      assign row_cur[r] = ~row_below_i[r];
    end else begin : g_rest
      assign row_cur[r] = ~row_below_i[r] & row_below_i[r-1];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign en_o[r*COLS+c] = row_below_i[r] | (row_cur[r] & col_below_i[c]);
    end
  end
endmodule

// File: rtl/dac_quad_decoder.sv
module dac_quad_decoder #(
  parameter int unsigned PHASE_W = 8,
  parameter int unsigned ROW_W   = 3,
  localparam int unsigned FOLD_W = PHASE_W - 2,
  localparam int unsigned COL_W  = FOLD_W - ROW_W,
  localparam int unsigned ROWS   = 1 << ROW_W,
  localparam int unsigned COLS   = 1 << COL_W,
  localparam int unsigned CELLS  = ROWS * COLS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [CELLS-1:0]   cell_en_o,
  output logic [CELLS-1:0]   sw_a_o,
  output logic [CELLS-1:0]   sw_b_o
);
  logic [FOLD_W-1:0] folded;
  logic              neg;
  logic [ROWS-1:0]   row_below;
  logic [COLS-1:0]   col_below;
  logic [CELLS-1:0]  en_d, a_d;
  logic [CELLS-1:0]  en_q, a_q, b_q;
  logic              primed_q;

  dac_quad_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase_i (phase_i),
    .folded_o(folded),
    .neg_o   (neg)
  );

  dac_therm #(.CODE_W(ROW_W)) u_row (
    .code_i (folded[FOLD_W-1 -: ROW_W]),
    .below_o(row_below)
  );

  dac_therm #(.CODE_W(COL_W)) u_col (
    .code_i (folded[COL_W-1:0]),
    .below_o(col_below)
  );

  dac_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cells (
    .row_below_i(row_below),
    .col_below_i(col_below),
    .en_o       (en_d)
  );

  assign a_d = en_d ^ {CELLS{neg}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      a_q      <= '0;
      b_q      <= '1;
      primed_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      a_q      <= a_d;
      b_q      <= ~a_d;
      primed_q <= 1'b1;
    end
  end

  assign cell_en_o = en_q;
  assign sw_a_o    = a_q;
  assign sw_b_o    = b_q;

  localparam int unsigned FMAX = (1 << FOLD_W) - 1;

  // R3
  cell_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |=> ($countones(en_q) ==
      ($past(phase_i[PHASE_W-2]) ? (FMAX - int'($past(phase_i[FOLD_W-1:0])))
                                 : int'($past(phase_i[FOLD_W-1:0])))));

  // R4
  contiguous_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q & (en_q + CELLS'(1))) == '0));

  // R5
  sign_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |=> (a_q == (en_q ^ {CELLS{$past(phase_i[PHASE_W-1])}})));

  // R5
  pair_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_q == ~a_q));
endmodule

// File: tb/tb_dac_quad_decoder.sv
`timescale 1ns/1ps
module tb_dac_quad_decoder;
  localparam int unsigned PHASE_W = 8;
  localparam int unsigned ROW_W   = 3;
  localparam int unsigned FOLD_W  = PHASE_W - 2;
  localparam int unsigned CELLS   = 1 << FOLD_W;
  localparam int unsigned NPH     = 1 << PHASE_W;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [PHASE_W-1:0] phase_i = '0;
  logic [CELLS-1:0]   cell_en_o, sw_a_o, sw_b_o;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  dac_quad_decoder #(.PHASE_W(PHASE_W), .ROW_W(ROW_W)) dut (
    .clk_i, .rst_ni, .phase_i, .cell_en_o, .sw_a_o, .sw_b_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [CELLS-1:0] act,
                     input logic [CELLS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int fold_of(input int p);
    int low;
    low = p % CELLS;
    return ((p >> FOLD_W) & 1) ? (CELLS - 1 - low) : low;
  endfunction

  function automatic logic [CELLS-1:0] mask_of(input int f);
    logic [CELLS-1:0] m;
    for (int n = 0; n < CELLS; n++) m[n] = (n < f);
    return m;
  endfunction

  initial begin
    logic [CELLS-1:0] prev_en, exp_en, exp_a;
    int f;
    repeat (3) @(negedge clk_i);
    // R1
    chk(cell_en_o == '0, "R1 en", cell_en_o, '0);
    chk(sw_a_o == '0, "R1 a", sw_a_o, '0);
    chk(sw_b_o == '1, "R1 b", sw_b_o, '1);
    rst_ni = 1'b1;
    prev_en = '0;
    for (int p = 0; p <= NPH; p++) begin
      @(negedge clk_i);
      phase_i = PHASE_W'(p % NPH);
      #1;
      // R6: nothing moves before the edge
      chk(cell_en_o == prev_en, "R6 hold", cell_en_o, prev_en);
      @(negedge clk_i);
      f      = fold_of(p % NPH);
      exp_en = mask_of(f);
      exp_a  = exp_en ^ {CELLS{phase_i[PHASE_W-1]}};
      // R2 R3 R4
      chk($countones(cell_en_o) == f, "R2/R3 count", CELLS'($countones(cell_en_o)), CELLS'(f));
      chk(cell_en_o == exp_en, "R4 mask", cell_en_o, exp_en);
      // R5
      chk(sw_a_o == exp_a, "R5 a", sw_a_o, exp_a);
      chk(sw_b_o == ~exp_a, "R5 b", sw_b_o, ~exp_a);
      // R7
      if (p > 0)
        chk($countones(cell_en_o ^ prev_en) <= 1, "R7 step", cell_en_o ^ prev_en, prev_en);
      prev_en = cell_en_o;
    end
    // R6: one-cycle latency on a jump
    @(negedge clk_i);
    phase_i = PHASE_W'(40);
    @(posedge clk_i);
    #1;
    chk(cell_en_o == mask_of(40), "R6 latency", cell_en_o, mask_of(40));
    // R1: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    chk(cell_en_o == '0 && sw_b_o == '1, "R1 async", cell_en_o, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule